// File: doc/BRIEF.md
# BLE Link-Layer CCM Packet Sequencer

This block steers an external 128-bit block cipher through the full CCM sequence for one Bluetooth LE link-layer packet. After a start pulse it captures a 13-byte nonce, the 2-byte packet header and the payload length. It then pulls the payload one byte at a time through a ready/valid stream. It issues one cipher request at a time and waits for the matching response. From the responses it builds the CBC-MAC tag and the CTR keystream. It emits the processed payload, followed by the 4 tag bytes, on a byte output. Key handling and the cipher rounds live outside the block; the cipher is assumed to hold a fixed 128-bit key.

In encrypt mode the payload stream is plaintext, and the output is ciphertext followed by the tag. In decrypt mode the payload stream is ciphertext followed by the 4 received tag bytes. The output is then the recovered plaintext followed by the tag computed over it, and a flag reports whether the received tag disagrees with the computed one. Software-facing registers and DMA belong to the surrounding subsystem.

Top module: `ccm_ble_seq`

## Requirements
- R1: The authentication chain begins with the cipher image of block `{8'h49, nonce[103:0], 16-bit payload length}`. It then enciphers that result XOR `{16'h0002, header[15:0], 96'h0}`, followed by one step per 16-byte payload block, each with the plaintext zero-padded. Byte 0 of every block sits in bits [127:120], and nonce byte 0 is nonce[103:96].
- R2: Payload byte k is XORed with byte (k mod 16) of the cipher image of counter block `{8'h01, nonce, 16-bit index}`, where the index is floor(k/16)+1. A short final block uses only the leading keystream bytes. Output bytes leave in input order.
- R3: The tag equals bits [127:96] of the final chaining value XOR bits [127:96] of the cipher image of counter block index 0. Its 4 bytes follow the last payload byte, most significant byte first.
- R4: The header is authenticated but never emitted: exactly payload length plus 4 bytes appear on the output per packet, and the output is quiet while idle.
- R5: In decrypt mode the chain runs over the recovered plaintext, and the 4 received tag bytes are taken from the input stream right after the payload. tag_mismatch is 1 exactly when they differ from the computed tag. It stays 0 for encryption and holds its value until the next accepted start.
- R6: A zero-length payload yields only the 4 tag bytes, computed over the header alone.
- R7: done is high for exactly one cycle, in the cycle after the last output byte.
- R8: A start pulse while busy is ignored; the packet in progress completes unchanged.
- R9: At most one cipher request is outstanding. cip_req_valid lasts one cycle per request, and a packet of n payload bytes takes 3 + 2*ceil(n/16) cipher calls.
- R10: After reset busy, done, out_valid, in_ready, cip_req_valid and tag_mismatch are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one packet (taken only while idle) |
| decrypt | input | 1 | 1 = decrypt and verify, 0 = encrypt |
| nonce | input | 104 | 13-byte nonce, byte 0 in the top bits |
| header | input | 16 | Packet header, authenticated only |
| pay_len | input | LEN_W | Payload length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte (payload, then received tag when decrypting) |
| in_ready | output | 1 | Block accepts an input byte |
| cip_req_valid | output | 1 | One-cycle cipher request |
| cip_req_block | output | 128 | Block to encipher |
| cip_resp_valid | input | 1 | Cipher response strobe |
| cip_resp_block | input | 128 | Enciphered block |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Processed payload byte or tag byte |
| done | output | 1 | One-cycle end-of-packet strobe |
| tag_mismatch | output | 1 | Received tag differs from computed tag |
| busy | output | 1 | Packet in progress |

## Verification
The bench builds the block with its default MAX_LEN of 255, so LEN_W is 8. That brings the full-length 255-byte packet within reach: sixteen blocks with a 15-byte tail, and counter indices up to 16. Around that sit zero-length, single-byte, exact-block and short-tail packets. The cipher model answers after a fixed three-cycle latency, so every request waits while earlier output bytes are still draining. Decrypt runs use ciphertext made by an encrypt reference, and are fed both a correct and a corrupted received tag.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    localparam int BLK_BYTES = 16;
    localparam int BLK_W     = 8 * BLK_BYTES;
    localparam int NONCE_W   = 104;
    localparam int HDR_W     = 16;
    localparam int TAG_BYTES = 4;
    localparam int TAG_W     = 8 * TAG_BYTES;
    localparam int CNT_W     = $clog2(BLK_BYTES + 1);

    localparam logic [7:0]  AUTH_FLAGS = 8'h49;
    localparam logic [7:0]  CTR_FLAGS  = 8'h01;
    localparam logic [15:0] AAD_BYTES  = 16'd2;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_AUTH0,
        SQ_AUTH1,
        SQ_FILL,
        SQ_KEYS,
        SQ_CHAIN,
        SQ_TAGKS,
        SQ_RXTAG,
        SQ_TXTAG,
        SQ_DRAIN,
        SQ_FIN
    } seq_st_e;

    function automatic blk_t auth_first(input logic [NONCE_W-1:0] n, input logic [15:0] len);
        return {AUTH_FLAGS, n, len};
    endfunction

    function automatic blk_t aad_block(input logic [HDR_W-1:0] h);
        return {AAD_BYTES, h, {(BLK_W-32){1'b0}}};
    endfunction

    function automatic blk_t ctr_block(input logic [NONCE_W-1:0] n, input logic [15:0] idx);
        return {CTR_FLAGS, n, idx};
    endfunction

    // keep the first n bytes (from the top), zero the rest
    function automatic blk_t keep_lead(input blk_t x, input logic [CNT_W-1:0] n);
        blk_t r;
        r = '0;
        for (int b = 0; b < BLK_BYTES; b++) begin
            if (b < int'(n)) r[BLK_W-1-8*b -: 8] = x[BLK_W-1-8*b -: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ccm_byte_gather.sv
module ccm_byte_gather
    import ccm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_cnt,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output blk_t             blk,
    output logic             full
);

    blk_t             blk_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] left_q;
    logic             full_q;

    assign in_ready = (left_q != '0);
    assign blk      = blk_q;
    assign full     = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= '0;
            idx_q  <= '0;
            left_q <= '0;
            full_q <= 1'b0;
        end else if (arm) begin
            blk_q  <= '0;
            idx_q  <= '0;
            left_q <= arm_cnt;
            full_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            for (int b = 0; b < BLK_BYTES; b++) begin
                if (CNT_W'(b) == idx_q) blk_q[BLK_W-1-8*b -: 8] <= in_data;
            end
            idx_q  <= idx_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) full_q <= 1'b1;
        end
    end

    // a new collection only starts once the previous one is complete (stream order, R2)
    assert_arm_idle_R2: assert property (@(posedge clk) disable iff (rst)
        arm |-> !in_ready);

endmodule

// File: rtl/ccm_byte_emit.sv
module ccm_byte_emit
    import ccm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  blk_t             load_blk,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             busy
);

    blk_t             sh_q;
    logic [CNT_W-1:0] left_q;

    assign out_valid = (left_q != '0);
    assign out_data  = sh_q[BLK_W-1 -: 8];
    assign out_last  = (left_q == CNT_W'(1));
    assign busy      = out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= load_blk;
            left_q <= load_cnt;
        end else if (left_q != '0) begin
            sh_q   <= {sh_q[BLK_W-9:0], 8'h00};
            left_q <= left_q - 1'b1;
        end
    end

    // a new block never cuts into bytes still leaving (ordering, R3)
    assert_load_idle_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

endmodule

// File: rtl/ccm_ble_seq.sv
module ccm_ble_seq
    import ccm_pkg::*;
#(
    parameter int MAX_LEN = 255,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int IDX_W  = $clog2(MAX_LEN / BLK_BYTES + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               decrypt,
    input  logic [103:0]       nonce,
    input  logic [15:0]        header,
    input  logic [LEN_W-1:0]   pay_len,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               cip_req_valid,
    output logic [127:0]       cip_req_block,
    input  logic               cip_resp_valid,
    input  logic [127:0]       cip_resp_block,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               done,
    output logic               tag_mismatch,
    output logic               busy
);

    seq_st_e              st_q;
    logic                 pend_q;
    logic                 dec_q;
    logic [NONCE_W-1:0]   nonce_q;
    logic [HDR_W-1:0]     hdr_q;
    logic [LEN_W-1:0]     len_q;
    logic [LEN_W-1:0]     rem_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    blk_t                 mac_q;
    blk_t                 ptxt_q;
    logic [TAG_W-1:0]     tag_q;
    logic                 mm_q;

    logic                 cip_phase;
    logic                 resp_hit;
    logic [LEN_W-1:0]     rem_after;
    logic [CNT_W-1:0]     next_cnt;
    blk_t                 ks_used;
    blk_t                 proc_blk;

    logic                 g_arm;
    logic [CNT_W-1:0]     g_cnt;
    blk_t                 g_blk;
    logic                 g_full;
    logic                 e_load;
    blk_t                 e_blk;
    logic [CNT_W-1:0]     e_cnt;
    logic                 e_last;
    logic                 e_busy;

    // ---------------- cipher port ----------------
    assign cip_phase = (st_q == SQ_AUTH0) || (st_q == SQ_AUTH1) || (st_q == SQ_KEYS) ||
                       (st_q == SQ_CHAIN) || (st_q == SQ_TAGKS);
    assign cip_req_valid = cip_phase && !pend_q;
    assign resp_hit      = cip_phase && pend_q && cip_resp_valid;

    always_comb begin
        unique case (st_q)
            SQ_AUTH0: cip_req_block = auth_first(nonce_q, 16'(len_q));
            SQ_AUTH1: cip_req_block = mac_q ^ aad_block(hdr_q);
            SQ_KEYS:  cip_req_block = ctr_block(nonce_q, 16'(idx_q));
            SQ_CHAIN: cip_req_block = mac_q ^ ptxt_q;
            SQ_TAGKS: cip_req_block = ctr_block(nonce_q, 16'd0);
            default:  cip_req_block = '0;
        endcase
    end

    // ---------------- block bookkeeping ----------------
    assign rem_after = (st_q == SQ_AUTH1) ? len_q : (rem_q - LEN_W'(cnt_q));
    assign next_cnt  = (rem_after >= LEN_W'(BLK_BYTES)) ? CNT_W'(BLK_BYTES) : CNT_W'(rem_after);
    assign ks_used   = keep_lead(cip_resp_block, cnt_q);
    assign proc_blk  = g_blk ^ ks_used;

    always_comb begin
        g_arm = 1'b0;
        g_cnt = next_cnt;
        if (resp_hit) begin
            if ((st_q == SQ_AUTH1 || st_q == SQ_CHAIN) && rem_after != '0) g_arm = 1'b1;
            if (st_q == SQ_TAGKS && dec_q) begin
                g_arm = 1'b1;
                g_cnt = CNT_W'(TAG_BYTES);
            end
        end
    end

    always_comb begin
        e_load = 1'b0;
        e_blk  = proc_blk;
        e_cnt  = cnt_q;
        if (st_q == SQ_KEYS && resp_hit) begin
            e_load = 1'b1;
        end else if (st_q == SQ_TXTAG && !e_busy) begin
            e_load = 1'b1;
            e_blk  = {tag_q, {(BLK_W-TAG_W){1'b0}}};
            e_cnt  = CNT_W'(TAG_BYTES);
        end
    end

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            pend_q  <= 1'b0;
            dec_q   <= 1'b0;
            nonce_q <= '0;
            hdr_q   <= '0;
            len_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            mac_q   <= '0;
            ptxt_q  <= '0;
            tag_q   <= '0;
            mm_q    <= 1'b0;
        end else begin
            if (cip_req_valid) pend_q <= 1'b1;
            else if (resp_hit) pend_q <= 1'b0;

            unique case (st_q)
                SQ_IDLE: if (start) begin
                    dec_q   <= decrypt;
                    nonce_q <= nonce;
                    hdr_q   <= header;
                    len_q   <= pay_len;
                    idx_q   <= IDX_W'(1);
                    mac_q   <= '0;
                    mm_q    <= 1'b0;
                    st_q    <= SQ_AUTH0;
                end
                SQ_AUTH0: if (resp_hit) begin
                    mac_q <= cip_resp_block;
                    st_q  <= SQ_AUTH1;
                end
                SQ_AUTH1: if (resp_hit) begin
                    mac_q <= cip_resp_block;
                    rem_q <= rem_after;
                    if (rem_after == '0) st_q <= SQ_TAGKS;
                    else begin
                        cnt_q <= next_cnt;
                        st_q  <= SQ_FILL;
                    end
                end
                SQ_FILL: if (g_full && !e_busy) st_q <= SQ_KEYS;
                SQ_KEYS: if (resp_hit) begin
                    ptxt_q <= dec_q ? proc_blk : g_blk;
                    st_q   <= SQ_CHAIN;
                end
                SQ_CHAIN: if (resp_hit) begin
                    mac_q <= cip_resp_block;
                    rem_q <= rem_after;
                    idx_q <= idx_q + 1'b1;
                    if (rem_after == '0) st_q <= SQ_TAGKS;
                    else begin
                        cnt_q <= next_cnt;
                        st_q  <= SQ_FILL;
                    end
                end
                SQ_TAGKS: if (resp_hit) begin
                    tag_q <= mac_q[BLK_W-1 -: TAG_W] ^ cip_resp_block[BLK_W-1 -: TAG_W];
                    st_q  <= dec_q ? SQ_RXTAG : SQ_TXTAG;
                end
                SQ_RXTAG: if (g_full) begin
                    mm_q <= (g_blk[BLK_W-1 -: TAG_W] != tag_q);
                    st_q <= SQ_TXTAG;
                end
                SQ_TXTAG: if (!e_busy) st_q <= SQ_DRAIN;
                SQ_DRAIN: if (e_last) st_q <= SQ_FIN;
                SQ_FIN:   st_q <= SQ_IDLE;
                default:  st_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy         = (st_q != SQ_IDLE);
    assign done         = (st_q == SQ_FIN);
    assign tag_mismatch = mm_q;

    ccm_byte_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .arm      (g_arm),
        .arm_cnt  (g_cnt),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .blk      (g_blk),
        .full     (g_full)
    );

    ccm_byte_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .load      (e_load),
        .load_blk  (e_blk),
        .load_cnt  (e_cnt),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (e_last),
        .busy      (e_busy)
    );

    // ---------------- assertions ----------------
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_req_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        cip_req_valid |=> !cip_req_valid);

    assert_mismatch_dec_only_R5: assert property (@(posedge clk) disable iff (rst)
        tag_mismatch |-> dec_q);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(len_q) && $stable(dec_q) && busy));

    assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid || in_ready) |-> busy);

endmodule

// File: tb/ccm_ble_seq_bench.sv
module ccm_ble_seq_bench;

    localparam int LAT = 3;
    localparam logic [127:0] KEY = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic [103:0] nonce = '0;
    logic [15:0]  header = '0;
    logic [7:0]   pay_len = '0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = '0;
    logic         in_ready;
    logic         cip_req_valid;
    logic [127:0] cip_req_block;
    logic         cip_resp_valid;
    logic [127:0] cip_resp_block;
    logic         out_valid;
    logic [7:0]   out_data;
    logic         done;
    logic         tag_mismatch;
    logic         busy;

    always #4 clk = ~clk;

    ccm_ble_seq u_ccm_ble_seq (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .nonce(nonce),
        .header(header), .pay_len(pay_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cip_req_valid(cip_req_valid), .cip_req_block(cip_req_block),
        .cip_resp_valid(cip_resp_valid), .cip_resp_block(cip_resp_block),
        .out_valid(out_valid), .out_data(out_data), .done(done),
        .tag_mismatch(tag_mismatch), .busy(busy)
    );

    function automatic logic [127:0] perm(input logic [127:0] x);
        logic [127:0] t;
        t = x ^ KEY;
        t = {t[120:0], t[127:121]};
        return t + KEY;
    endfunction

    // cipher model: fixed latency, one request at a time
    logic [127:0] hold_blk;
    int           lat_cnt;
    always @(posedge clk) begin
        cip_resp_valid <= 1'b0;
        if (rst) begin
            lat_cnt <= 0;
            cip_resp_block <= '0;
        end else if (cip_req_valid) begin
            hold_blk <= perm(cip_req_block);
            lat_cnt  <= LAT;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                cip_resp_valid <= 1'b1;
                cip_resp_block <= hold_blk;
            end
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference CCM from the requirements
    logic [7:0] ref_in  [256];
    logic [7:0] ref_out [256];

    function automatic logic [31:0] ref_ccm(input bit dec, input logic [103:0] n,
                                            input logic [15:0] h, input int len);
        logic [127:0] x, s, p;
        logic [7:0]   o;
        int nb;
        x  = perm({8'h49, n, 16'(len)});
        x  = perm(x ^ {16'h0002, h, 96'h0});
        nb = (len + 15) / 16;
        for (int i = 0; i < nb; i++) begin
            s = perm({8'h01, n, 16'(i + 1)});
            p = '0;
            for (int b = 0; b < 16; b++) begin
                if (i * 16 + b < len) begin
                    o = ref_in[i*16+b] ^ s[127-8*b -: 8];
                    ref_out[i*16+b] = o;
                    p[127-8*b -: 8] = dec ? o : ref_in[i*16+b];
                end
            end
            x = perm(x ^ p);
        end
        s = perm({8'h01, n, 16'd0});
        return x[127:96] ^ s[127:96];
    endfunction

    // scoreboard
    logic [7:0] exp_q[$];
    string      why_q[$];
    logic       exp_mm;
    int         exp_calls;
    int         calls = 0;
    int         dones = 0;
    bit         outst = 1'b0;
    bit         last_ov = 1'b0;
    bit         prev_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cip_resp_valid) outst = 1'b0;
            if (cip_req_valid) begin
                chk(!outst, "R9 overlapping cipher request", 1, 0);
                outst = 1'b1;
                calls++;
            end
            if (out_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 extra output byte", out_data, 0);
                else begin
                    logic [7:0] e;
                    string w;
                    e = exp_q.pop_front();
                    w = why_q.pop_front();
                    chk(out_data == e, w, out_data, e);
                end
            end
            if (done) begin
                chk(last_ov, "R7 done follows last byte", 0, 1);
                chk(exp_q.size() == 0, "R4 byte count", exp_q.size(), 0);
                chk(tag_mismatch == exp_mm, "R5 mismatch flag", tag_mismatch, exp_mm);
                chk(calls == exp_calls, "R9 cipher call count", calls, exp_calls);
                dones++;
            end
            chk(!(prev_done && done), "R7 done one cycle", 1, 0);
            last_ov   = out_valid;
            prev_done = done;
        end
    end

    logic [7:0] pt [256];
    logic [7:0] stream [260];

    task automatic run_pkt(input bit dec, input logic [103:0] n, input logic [15:0] h,
                           input int len, input bit bad, input bit poke, input int seed);
        logic [31:0] t, t2;
        int d0, nin;
        for (int i = 0; i < len; i++) pt[i] = 8'(i * seed + seed * 7 + 3);
        for (int i = 0; i < len; i++) ref_in[i] = pt[i];
        t = ref_ccm(1'b0, n, h, len);
        if (!dec) begin
            for (int i = 0; i < len; i++) begin
                stream[i] = pt[i];
                exp_q.push_back(ref_out[i]);
                why_q.push_back("R2 payload byte");
            end
            nin = len;
            t2  = t;
        end else begin
            for (int i = 0; i < len; i++) begin
                stream[i] = ref_out[i];
                ref_in[i] = ref_out[i];
            end
            t2 = ref_ccm(1'b1, n, h, len);
            for (int i = 0; i < len; i++) begin
                exp_q.push_back(ref_out[i]);
                why_q.push_back("R5 recovered plaintext byte");
            end
            for (int b = 0; b < 4; b++) stream[len+b] = (bad ? (t ^ 32'h0100_0000) : t) >> (24 - 8*b);
            nin = len + 4;
        end
        for (int b = 0; b < 4; b++) begin
            exp_q.push_back(8'(t2 >> (24 - 8*b)));
            why_q.push_back(len == 0 ? "R6 header-only tag byte" : "R3 tag byte");
        end
        exp_mm    = dec && bad;
        exp_calls = 3 + 2 * ((len + 15) / 16);
        d0 = dones;
        @(negedge clk);
        calls   = 0;
        start   = 1'b1;
        decrypt = dec;
        nonce   = n;
        header  = h;
        pay_len = 8'(len);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R8: a second start with other settings while busy
            start   = 1'b1;
            decrypt = ~dec;
            pay_len = 8'(len + 9);
            nonce   = ~n;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < nin; i++) begin
            if (i != 0) @(negedge clk);
            in_valid = 1'b1;
            in_data  = stream[i];
            while (!in_ready) @(negedge clk);
        end
        if (nin != 0) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        while (dones == d0) @(negedge clk);
        @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !out_valid, "R10 reset outputs", {busy, done, out_valid}, 0);
        chk(!in_ready && !cip_req_valid && !tag_mismatch, "R10 reset handshakes",
            {in_ready, cip_req_valid, tag_mismatch}, 0);

        run_pkt(1'b0, 104'h0102030405060708090a0b0c0d, 16'h1b02, 27, 1'b0, 1'b0, 5);   // R1 R2 R3
        run_pkt(1'b0, 104'hfedcba98765432100123456789, 16'h0003, 0, 1'b0, 1'b0, 3);    // R6
        run_pkt(1'b0, 104'h00000000000000000000000001, 16'h1002, 16, 1'b0, 1'b0, 11);  // exact block
        run_pkt(1'b0, 104'h5a5a5a5a5a5a5a5a5a5a5a5a5a, 16'h0102, 1, 1'b0, 1'b0, 9);    // single byte
        run_pkt(1'b0, 104'h1122334455667788990011aabb, 16'hff0e, 255, 1'b0, 1'b0, 13); // maximum length
        run_pkt(1'b1, 104'h0102030405060708090a0b0c0d, 16'h1b02, 27, 1'b0, 1'b0, 5);   // R5 good tag
        run_pkt(1'b1, 104'h0a0b0c0d0e0f10111213141516, 16'h2806, 40, 1'b1, 1'b0, 17);  // R5 bad tag
        repeat (3) @(negedge clk);
        chk(tag_mismatch == 1'b1, "R5 mismatch held after done", tag_mismatch, 1);
        run_pkt(1'b0, 104'h99887766554433221100aabbcc, 16'h1402, 20, 1'b0, 1'b1, 7);   // R8 poke
        run_pkt(1'b1, 104'h77777777777777777777777777, 16'h0001, 0, 1'b0, 1'b0, 2);    // R6 decrypt empty
        run_pkt(1'b1, 104'h31415926535897932384626433, 16'h2102, 33, 1'b1, 1'b1, 21);  // R5 R8 combined

        repeat (5) @(negedge clk);
        chk(!busy && !out_valid && !in_ready, "R4 quiet when idle", {busy, out_valid, in_ready}, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule